// File: doc/BRIEF.md
# Observability Scanout Chain with Signature Compaction

This block is a shadow register chain that watches a chosen set of functional state nodes. Each stage reads one functional flop through a parallel tap and never drives anything back toward it, so the logic under observation keeps running as it would without the chain. The stage count is a parameter, so a chain covers only as many nodes as are worth the clock load.

Two global controls, `smp_i` and `shf_i`, choose the action on each clock. The chain can hold, take a parallel snapshot, shift one place toward the serial output, or compact. Compacting XORs each stage's serial input with its observed node on every cycle, so continuous activity builds a signature. A small unload controller, started by `unl_start_i`, shifts the chain out over exactly N cycles, raises a busy flag while it runs and pulses a completion flag at the end. The serial input of the first stage is a port, so several chains can be joined end to end.

Top module: `obs_chain`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first update, every stage is 0, `sout_o` is 0 and `busy_o` and `done_o` are 0.
- R2: With `busy_o` low, `unl_start_i` low, `smp_i` = 0 and `shf_i` = 0, every stage keeps its value across the clock.
- R3: With `busy_o` low, `unl_start_i` low, `smp_i` = 1 and `shf_i` = 0, stage i loads `obs_i[i]` for every i in one clock.
- R4: With `busy_o` low, `unl_start_i` low, `smp_i` = 0 and `shf_i` = 1, stage 0 loads `sin_i` and stage i loads the old stage i-1 for i ≥ 1.
- R5: With `busy_o` low, `unl_start_i` low and both `smp_i` and `shf_i` = 1, stage 0 loads `sin_i ^ obs_i[0]` and stage i loads old stage i-1 XOR `obs_i[i]`.
- R6: `unl_start_i` seen while `busy_o` is low leaves the chain unchanged on that clock, and `busy_o` is high for exactly the next N clocks. The chain shifts as in R4 on each of those clocks.
- R7: While `busy_o` is high, `smp_i`, `shf_i`, `unl_start_i` and `obs_i` have no effect. The chain only shifts.
- R8: `done_o` is high for exactly the one cycle after `busy_o` falls and is low otherwise.
- R9: `sout_o` always equals stage N-1, and `chain_o[i]` is stage i, with stage 0 nearest `sin_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears all stages |
| smp_i | input | 1 | Sample control |
| shf_i | input | 1 | Shift control |
| unl_start_i | input | 1 | Request an N-cycle unload |
| sin_i | input | 1 | Serial input to stage 0 |
| obs_i | input | N | Taps from the observed functional flops |
| chain_o | output | N | Contents of all stages, bit i is stage i |
| sout_o | output | 1 | Serial output, the last stage |
| busy_o | output | 1 | Unload in progress |
| done_o | output | 1 | One-cycle pulse after an unload completes |

## Verification
A wrong stage value shows on `chain_o` one clock after the bad update. It reaches `sout_o` after at most N further shifts, and in signature mode it stays in the XOR stream from then on. A miscounted unload shows as `busy_o` falling a cycle early or late, with `done_o` moved along with it. A missed gating shows as the chain taking a snapshot in the middle of an unload, which changes the next serial bit at once.

// File: rtl/obs_chain.sv
module obs_chain #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_i,
  input  logic         shf_i,
  input  logic         unl_start_i,
  input  logic         sin_i,
  input  logic [N-1:0] obs_i,
  output logic [N-1:0] chain_o,
  output logic         sout_o,
  output logic         busy_o,
  output logic         done_o
);
  localparam int CW = $clog2(N + 1);

  logic [CW-1:0] cnt;
  logic [N-1:0]  prev;
  logic [N-1:0]  nxt;
  logic          launch;

  assign prev   = {chain_o[N-2:0], sin_i};
  assign busy_o = (cnt != '0);
  assign launch = unl_start_i && !busy_o;
  assign sout_o = chain_o[N-1];

  always_comb begin
    if (busy_o)      nxt = prev;
    else if (launch) nxt = chain_o;
    else begin
      unique case ({smp_i, shf_i})
        2'b00:   nxt = chain_o;
        2'b10:   nxt = obs_i;
        2'b01:   nxt = prev;
        default: nxt = prev ^ obs_i;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_o <= '0;
      cnt     <= '0;
      done_o  <= 1'b0;
    end else begin
      chain_o <= nxt;
      done_o  <= busy_o && (cnt == CW'(1));
      if (busy_o)      cnt <= cnt - CW'(1);
      else if (launch) cnt <= CW'(N);
    end
  end

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !unl_start_i && !smp_i && !shf_i) |=> $stable(chain_o)); // R2
  AST_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !unl_start_i && smp_i && !shf_i) |=> chain_o == $past(obs_i)); // R3
  AST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !unl_start_i && !smp_i && shf_i)
      |=> chain_o == {$past(chain_o[N-2:0]), $past(sin_i)}); // R4
  AST_SIG: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !unl_start_i && smp_i && shf_i)
      |=> chain_o == ({$past(chain_o[N-2:0]), $past(sin_i)} ^ $past(obs_i))); // R5
  AST_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (unl_start_i && !busy_o) |=> busy_o && $stable(chain_o)); // R6
  AST_BUSY_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> chain_o == {$past(chain_o[N-2:0]), $past(sin_i)}); // R7
  AST_DONE_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o); // R8
  AST_DONE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && $past(busy_o)); // R8
endmodule

// File: tb/tb_obs_chain.sv
module tb_obs_chain;
  localparam int N = 4;
  localparam int TCLK = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_i = 1'b0, shf_i = 1'b0, unl_start_i = 1'b0, sin_i = 1'b0;
  logic [N-1:0] obs_i = '0;
  logic [N-1:0] chain_o;
  logic sout_o, busy_o, done_o;

  int n_chk = 0, n_bad = 0;
  logic [N-1:0] m_chain = '0;
  int m_busy = 0;
  logic m_done = 1'b0;

  always #(TCLK/2) clk = ~clk;

  obs_chain #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .smp_i(smp_i), .shf_i(shf_i),
    .unl_start_i(unl_start_i), .sin_i(sin_i), .obs_i(obs_i),
    .chain_o(chain_o), .sout_o(sout_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(chain_o == m_chain, {tag, " chain"}, chain_o, m_chain);
    chk(sout_o == m_chain[N-1], "R9 sout", sout_o, m_chain[N-1]);
    chk(busy_o == (m_busy != 0), {tag, " busy"}, busy_o, m_busy != 0);
    chk(done_o == m_done, "R8 done", done_o, m_done);
  endtask

  task automatic step(input bit s, input bit h, input bit st, input bit si,
                      input logic [N-1:0] o);
    string tag;
    logic [N-1:0] sh;
    smp_i = s; shf_i = h; unl_start_i = st; sin_i = si; obs_i = o;
    sh = {m_chain[N-2:0], si};
    m_done = 1'b0;
    if (m_busy != 0) begin
      tag = "R7"; m_chain = sh; m_busy--; m_done = (m_busy == 0);
    end else if (st) begin
      tag = "R6"; m_busy = N;
    end else if (!s && !h) tag = "R2";
    else if (s && !h) begin tag = "R3"; m_chain = o; end
    else if (!s && h) begin tag = "R4"; m_chain = sh; end
    else begin tag = "R5"; m_chain = sh ^ o; end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(TCLK * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    for (int md = 0; md < 4; md++)
      for (int o = 0; o < (1 << N); o++)
        for (int si = 0; si < 2; si++)
          step(md[1], md[0], 1'b0, si[0], o[N-1:0]);

    for (int v = 0; v < (1 << N); v++) begin
      step(1'b1, 1'b0, 1'b0, 1'b0, v[N-1:0]);
      step(1'b0, 1'b0, 1'b1, 1'b0, ~v[N-1:0]);
      for (int k = 0; k < N; k++)
        step(k[0], 1'b1, 1'b1, v[k], ~v[N-1:0]);
      step(1'b0, 1'b0, 1'b0, 1'b0, '0);
    end

    step(1'b0, 1'b0, 1'b1, 1'b1, '0);
    step(1'b0, 1'b0, 1'b1, 1'b1, '0);
    for (int k = 0; k < N + 2; k++)
      step(1'b1, 1'b1, 1'b0, 1'b0, 4'h5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule